// File: doc/BRIEF.md
# Sign-Bit Complex Crosscorrelator for Symbol Timing

This block finds the symbol timing of a received frame. It compares the incoming complex samples with a fixed reference waveform taken from the long training symbol. It is placed after the frequency-offset correction stage and is armed only once that correction is running. Each sample contributes only the sign of its real part and the sign of its imaginary part. The reference is a hard-wired constant, so every tap's complex product needs no multiplier: each partial product reduces to a plain wire or a single inverter on a sign bit.

A window of the last `TAPS` sign pairs (default 32) is correlated against the conjugated reference on every accepted sample. The block outputs |re| + |im| of the complex sum. The long preamble holds two copies of the reference pattern, but the first match is enough. The first magnitude that strictly exceeds the threshold raises a one-cycle timing strobe, and the block then disables itself until the next arm pulse.

Top module: `sign_xcorr`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, `busy`, `mag_valid`, `peak_strobe` and `mag_out` are all zero.
- R2: A one-cycle `arm` pulse sets `busy` one clock later. While `busy` is low, samples are ignored and produce no `mag_valid`.
- R3: Only the sign of each sample takes part (bit DATA_W-1 of `in_re`/`in_im`, 1 = negative). Feeding the reference pattern with any magnitudes gives the full-match magnitude 2*TAPS.
- R4: The reference bit pair for element j (j = 0 first in time) is bit j of `REF_RE`/`REF_IM`, where 1 = negative. With x the ±1 sign value of the sample k places back (k = 0 newest) and c the ±1 sign value of reference element TAPS-1-k, the complex sum is Σ x·conj(c).
- R5: `mag_out` = |Re| + |Im| of that sum. It is shown with `mag_valid` high in the second cycle after the clock edge that accepts the sample.
- R6: No `mag_valid` is produced until TAPS samples have been accepted since the latest arm.
- R7: `peak_strobe` rises one clock after the first `mag_valid` cycle whose magnitude exceeds `threshold`, and it lasts exactly one cycle.
- R8: `busy` falls together with the strobe. Samples offered afterwards produce no magnitude and no further strobe until the block is re-armed.
- R9: An `arm` pulse while busy restarts the window: the sample offered in the arm cycle is dropped, and TAPS new samples are needed before the next magnitude.
- R10: If `arm` coincides with a threshold crossing, the strobe is still issued, `busy` stays high, and the window starts afresh.
- R11: The comparison is strict: a magnitude equal to `threshold` does not strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle pulse that starts or restarts a search |
| in_valid | input | 1 | Sample qualifier |
| in_re | input | DATA_W | Real part, two's complement |
| in_im | input | DATA_W | Imaginary part, two's complement |
| threshold | input | MAG_W | Detection threshold, strict greater-than |
| mag_out | output | MAG_W | Correlation magnitude |
| mag_valid | output | 1 | `mag_out` holds a new value |
| peak_strobe | output | 1 | One-cycle timing strobe |
| busy | output | 1 | Search in progress |

## Verification
The threshold crossing that ends a search and a fresh `arm` pulse can land in the same cycle. The strobe must survive, the block must stay armed, and the stale in-flight magnitude must not strobe again. The bench provokes this by tracking its own predicted crossing and raising `arm` exactly in that cycle. It then checks that one strobe appears, that `busy` remains high, and that no magnitude or strobe follows until a full new window has been filled. A second overlap, an arm pulse together with a valid sample, is driven mid-frame and judged by the dropped sample delaying the next magnitude.

// File: rtl/sxc_pkg.sv
package sxc_pkg;

  // Real part of one sample-times-conjugated-reference term, from sign bits (1 = negative).
  function automatic logic signed [2:0] term_re(input logic dr, input logic di,
                                                input logic cr, input logic ci);
    logic signed [2:0] p, q;
    p = (dr == cr) ? 3'sd1 : -3'sd1;
    q = (di == ci) ? 3'sd1 : -3'sd1;
    return p + q;
  endfunction

  // Imaginary part of the same term: di*cr - dr*ci.
  function automatic logic signed [2:0] term_im(input logic dr, input logic di,
                                                input logic cr, input logic ci);
    logic signed [2:0] p, q;
    p = (di == cr) ? 3'sd1 : -3'sd1;
    q = (dr != ci) ? 3'sd1 : -3'sd1;
    return p + q;
  endfunction

  // L1 magnitude of a complex value.
  function automatic logic [15:0] l1_mag(input logic signed [15:0] re,
                                         input logic signed [15:0] im);
    logic [15:0] ar, ai;
    ar = (re < 0) ? 16'(-re) : 16'(re);
    ai = (im < 0) ? 16'(-im) : 16'(im);
    return ar + ai;
  endfunction

endpackage

// File: rtl/sxc_window.sv
module sxc_window #(
  parameter int TAPS  = 32,
  parameter int CNT_W = $clog2(TAPS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            shift,
  input  logic            d_re_neg,
  input  logic            d_im_neg,
  output logic [TAPS-1:0] win_re,
  output logic [TAPS-1:0] win_im,
  output logic            full
);
  localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(TAPS);

  logic [CNT_W-1:0] fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_re <= '0;
      win_im <= '0;
    end else if (shift) begin
      win_re <= {win_re[TAPS-2:0], d_re_neg};
      win_im <= {win_im[TAPS-2:0], d_im_neg};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         fill <= '0;
    else if (clear)                     fill <= '0;
    else if (shift && fill != FILL_MAX) fill <= fill + 1'b1;
  end

  assign full = (fill == FILL_MAX);

  // R6: the fill count never passes the window length
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_MAX);

  // R9: an arm pulse always empties the window count
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> fill == '0);

endmodule

// File: rtl/sxc_tapsum.sv
module sxc_tapsum
  import sxc_pkg::*;
#(
  parameter int              TAPS   = 32,
  parameter logic [TAPS-1:0] REF_RE = '0,
  parameter logic [TAPS-1:0] REF_IM = '0,
  parameter int              SUM_W  = 8
) (
  input  logic [TAPS-1:0]    win_re,
  input  logic [TAPS-1:0]    win_im,
  output logic [SUM_W-1:0]   sum_re,
  output logic [SUM_W-1:0]   sum_im
);
  logic signed [2:0] t_re [TAPS];
  logic signed [2:0] t_im [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam logic CR = REF_RE[TAPS-1-k];
    localparam logic CI = REF_IM[TAPS-1-k];
    assign t_re[k] = term_re(win_re[k], win_im[k], CR, CI);
    assign t_im[k] = term_im(win_re[k], win_im[k], CR, CI);
  end

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int i = 0; i < TAPS; i++) begin
      sum_re = sum_re + {{(SUM_W-3){t_re[i][2]}}, t_re[i]};
      sum_im = sum_im + {{(SUM_W-3){t_im[i][2]}}, t_im[i]};
    end
  end

endmodule

// File: rtl/sign_xcorr.sv
module sign_xcorr
  import sxc_pkg::*;
#(
  parameter int              DATA_W = 12,
  parameter int              TAPS   = 32,
  parameter logic [TAPS-1:0] REF_RE = 32'h3A5C_91E6,
  parameter logic [TAPS-1:0] REF_IM = 32'hC5D2_0B7F,
  localparam int             MAG_W  = $clog2(2 * TAPS + 1),
  localparam int             SUM_W  = MAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  input  logic [MAG_W-1:0]  threshold,
  output logic [MAG_W-1:0]  mag_out,
  output logic              mag_valid,
  output logic              peak_strobe,
  output logic              busy
);
  localparam int CNT_W = $clog2(TAPS + 1);

  // named internal events
  logic              accept;
  logic              win_full;
  logic              acc_q;
  logic              hit;
  logic [TAPS-1:0]   win_re, win_im;
  logic [SUM_W-1:0]  sum_re, sum_im;
  logic [15:0]       mag_full;

  assign accept = busy && in_valid && !arm;

  sxc_window #(.TAPS(TAPS), .CNT_W(CNT_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (arm),
    .shift    (accept),
    .d_re_neg (in_re[DATA_W-1]),
    .d_im_neg (in_im[DATA_W-1]),
    .win_re   (win_re),
    .win_im   (win_im),
    .full     (win_full)
  );

  sxc_tapsum #(.TAPS(TAPS), .REF_RE(REF_RE), .REF_IM(REF_IM), .SUM_W(SUM_W)) u_tapsum (
    .win_re (win_re),
    .win_im (win_im),
    .sum_re (sum_re),
    .sum_im (sum_im)
  );

  assign mag_full = l1_mag({{(16-SUM_W){sum_re[SUM_W-1]}}, sum_re},
                           {{(16-SUM_W){sum_im[SUM_W-1]}}, sum_im});

  // magnitude stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= 1'b0;
      mag_valid <= 1'b0;
      mag_out   <= '0;
    end else begin
      acc_q     <= accept;
      mag_valid <= acc_q && win_full && !arm;
      if (acc_q) mag_out <= mag_full[MAG_W-1:0];
    end
  end

  // registered threshold decision and search state
  assign hit = busy && mag_valid && (mag_out > threshold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_strobe <= 1'b0;
      busy        <= 1'b0;
    end else begin
      peak_strobe <= hit;
      busy        <= arm || (busy && !hit);
    end
  end

  // R3: the window captures exactly the negativity of each accepted sample
  a_r3_sign_capture_re: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> win_re[0] == $past($signed(in_re) < 0));
  a_r3_sign_capture_im: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> win_im[0] == $past($signed(in_im) < 0));

  // R5: the full-width magnitude never exceeds the full-match value
  a_r5_mag_bound: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> mag_full <= 16'(2 * TAPS));

  // R2: a magnitude only follows a sample taken while busy
  a_r2_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mag_valid |-> $past(busy, 2));

  // R6: a magnitude only comes from a full window
  a_r6_valid_full: assert property (@(posedge clk) disable iff (!rst_n)
    mag_valid |-> $past(win_full));

  // R7: the strobe lasts one cycle and follows a crossing
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    peak_strobe |=> !peak_strobe);
  a_r7_after_crossing: assert property (@(posedge clk) disable iff (!rst_n)
    peak_strobe |-> $past(mag_valid) && ($past(mag_out) > $past(threshold)));

  // R8 / R10: busy after a strobe equals whether arm came with the crossing
  a_r8_self_disable: assert property (@(posedge clk) disable iff (!rst_n)
    peak_strobe |-> busy == $past(arm));

endmodule

// File: tb/sign_xcorr_bench.sv
`timescale 1ns/1ps
module sign_xcorr_bench;
  localparam int              DW     = 12;
  localparam int              TAPS   = 32;
  localparam int              MW     = $clog2(2 * TAPS + 1);
  localparam logic [TAPS-1:0] REF_RE = 32'h3A5C_91E6;
  localparam logic [TAPS-1:0] REF_IM = 32'hC5D2_0B7F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 1'b0, in_valid = 1'b0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic [MW-1:0] threshold = '0;
  logic [MW-1:0] mag_out;
  logic mag_valid, peak_strobe, busy;

  always #5 clk = ~clk;

  sign_xcorr #(.DATA_W(DW), .TAPS(TAPS), .REF_RE(REF_RE), .REF_IM(REF_IM)) u_sign_xcorr (
    .clk(clk), .rst_n(rst_n), .arm(arm), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .threshold(threshold), .mag_out(mag_out), .mag_valid(mag_valid),
    .peak_strobe(peak_strobe), .busy(busy));

  int n_tests = 0, n_fail = 0;
  int n_valid = 0, n_peak = 0, last_mag = 0;
  int thr = 0;
  bit arm_at_hit = 0, arm_hit_seen = 0, finished = 0;

  // bench model of the required behaviour
  bit m_busy = 0, m_acc = 0, m_magv = 0, m_peak = 0;
  int m_fill = 0, m_mag = 0;
  bit w_re [TAPS];
  bit w_im [TAPS];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // complex correlation magnitude from the requirement definition
  function automatic int corr_mag();
    int re = 0, im = 0;
    for (int k = 0; k < TAPS; k++) begin
      int xr = w_re[k] ? -1 : 1;
      int xi = w_im[k] ? -1 : 1;
      int cr = REF_RE[TAPS-1-k] ? -1 : 1;
      int ci = REF_IM[TAPS-1-k] ? -1 : 1;
      re += xr * cr + xi * ci;
      im += xi * cr - xr * ci;
    end
    return (re < 0 ? -re : re) + (im < 0 ? -im : im);
  endfunction

  task automatic cycle(input bit a, input bit v, input logic [DW-1:0] re, input logic [DW-1:0] im);
    bit hit, acc, nv, a_eff;
    int nm;
    @(negedge clk);
    chk(busy == m_busy, "R2 busy", busy, m_busy);
    chk(mag_valid == m_magv, "R6 mag_valid", mag_valid, m_magv);
    if (m_magv) chk(int'(mag_out) == m_mag, "R4 R5 magnitude", mag_out, m_mag);
    chk(peak_strobe == m_peak, "R7 strobe", peak_strobe, m_peak);
    if (mag_valid) begin n_valid++; last_mag = mag_out; end
    if (peak_strobe) n_peak++;
    hit = m_busy && m_magv && (m_mag > thr);
    a_eff = a;
    if (arm_at_hit && hit) begin a_eff = 1; arm_hit_seen = 1; end
    arm = a_eff; in_valid = v; in_re = re; in_im = im; threshold = MW'(thr);
    acc = m_busy && v && !a_eff;
    nv  = m_acc && (m_fill == TAPS) && !a_eff;
    nm  = m_acc ? corr_mag() : m_mag;
    if (acc) begin
      for (int k = TAPS - 1; k > 0; k--) begin w_re[k] = w_re[k-1]; w_im[k] = w_im[k-1]; end
      w_re[0] = re[DW-1]; w_im[0] = im[DW-1];
    end
    if (a_eff) m_fill = 0;
    else if (acc && m_fill < TAPS) m_fill++;
    m_magv = nv; m_mag = nm; m_peak = hit;
    m_busy = a_eff || (m_busy && !hit);
    m_acc = acc;
  endtask

  function automatic logic [DW-1:0] with_sign(input bit neg);
    logic [DW-1:0] r = DW'($urandom);
    r[DW-1] = neg;
    return r;
  endfunction

  task automatic rand_sample(input bit a);
    cycle(a, 1'b1, DW'($urandom), DW'($urandom));
  endtask

  task automatic ref_sample(input int j);
    cycle(1'b0, 1'b1, with_sign(REF_RE[j]), with_sign(REF_IM[j]));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v0, p0;
    void'($urandom(32'd20240611));
    for (int k = 0; k < TAPS; k++) begin w_re[k] = 0; w_im[k] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !mag_valid && !peak_strobe && mag_out == '0, "R1 reset outputs",
        {busy, mag_valid, peak_strobe}, 0);
    rst_n = 1'b1;
    idle(1);
    chk(!busy && !mag_valid && !peak_strobe, "R1 after release", busy, 0);

    // R2: idle block ignores samples
    for (int i = 0; i < 40; i++) rand_sample(1'b0);
    idle(2);
    chk(n_valid == 0, "R2 ignored while idle", n_valid, 0);

    // R6: arm then 31 samples: nothing yet; the 32nd brings one magnitude
    thr = 64;
    cycle(1'b1, 1'b0, '0, '0);
    for (int i = 0; i < TAPS - 1; i++) rand_sample(1'b0);
    idle(3);
    chk(n_valid == 0, "R6 no magnitude before window full", n_valid, 0);
    rand_sample(1'b0);
    idle(3);
    chk(n_valid == 1, "R6 first magnitude on full window", n_valid, 1);

    // R3 + R11: reference pattern with random magnitudes, threshold equal to full match
    p0 = n_peak;
    cycle(1'b1, 1'b0, '0, '0);
    for (int j = 0; j < TAPS; j++) ref_sample(j);
    idle(3);
    chk(last_mag == 2 * TAPS, "R3 sign-only full match", last_mag, 2 * TAPS);
    chk(n_peak == p0, "R11 equal does not strobe", n_peak - p0, 0);

    // R7: one below full match strobes once
    thr = 2 * TAPS - 1;
    cycle(1'b1, 1'b0, '0, '0);
    for (int j = 0; j < TAPS; j++) ref_sample(j);
    idle(3);
    chk(n_peak == p0 + 1, "R7 single strobe on crossing", n_peak - p0, 1);
    chk(busy == 1'b0, "R8 disabled after strobe", busy, 0);

    // R8: further samples are ignored
    v0 = n_valid; p0 = n_peak;
    for (int j = 0; j < TAPS; j++) ref_sample(j);
    idle(3);
    chk(n_valid == v0 && n_peak == p0, "R8 no activity until re-armed", n_valid - v0, 0);

    // R9: re-arm mid-frame together with a valid sample
    thr = 63;
    cycle(1'b1, 1'b0, '0, '0);
    for (int i = 0; i < 20; i++) rand_sample(1'b0);
    v0 = n_valid;
    rand_sample(1'b1);
    for (int i = 0; i < TAPS - 1; i++) rand_sample(1'b0);
    idle(3);
    chk(n_valid == v0, "R9 window restarted, arm sample dropped", n_valid - v0, 0);
    rand_sample(1'b0);
    idle(3);
    chk(n_valid == v0 + 1, "R9 magnitude after fresh window", n_valid - v0, 1);

    // R10: arm lands in the crossing cycle
    thr = 40;
    cycle(1'b1, 1'b0, '0, '0);
    p0 = n_peak;
    arm_at_hit = 1;
    for (int j = 0; j < TAPS; j++) ref_sample(j);
    for (int i = 0; i < 4; i++) rand_sample(1'b0);
    arm_at_hit = 0;
    chk(arm_hit_seen, "R10 arm placed on crossing", arm_hit_seen, 1);
    chk(n_peak == p0 + 1, "R10 strobe kept", n_peak - p0, 1);
    chk(busy == 1'b1, "R10 stays armed", busy, 1);
    for (int i = 0; i < TAPS - 8; i++) rand_sample(1'b0);
    chk(n_peak == p0 + 1, "R10 no stale strobe", n_peak - p0, 1);

    // random rounds mixing reference runs and noise
    for (int r = 0; r < 10; r++) begin
      thr = 24 + int'($urandom % 36);
      cycle(1'b1, 1'b0, '0, '0);
      for (int i = 0; i < 90; i++) begin
        int sel = int'($urandom % 100);
        if (sel < 45) ref_sample(i % TAPS);
        else if (sel < 80) rand_sample(sel == 79);
        else cycle(1'b0, 1'b0, DW'($urandom), DW'($urandom));
      end
    end
    idle(4);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule